// File: doc/BRIEF.md
# Octal SPI Command Phase Sequencer

This block runs one transaction at a time on a serial memory bus that has up to eight data lines. A transaction is a chain of up to four phases: instruction, address, dummy cycles and data. Each phase can be skipped. Each phase also has its own line count, so a command can go out on one line while the data moves on four or eight. The register side holds the configuration, opcode, address, byte count and clock prescaler. The sequencer latches these values when the launch strobe arrives, which matches a write to the instruction register.

Bytes to send are pushed into a small transmit FIFO. Bytes received are popped from a receive FIFO. Both FIFOs use byte-wide valid/ready ports. The sequencer drives the serial clock, two active-low chip selects and the data lines, given as separate out, enable and in vectors. It reports busy, transfer complete and transfer error. A pending abort bit rises on an abort request and clears itself once the bus has been released.

Top module: `ospi_seq`

## Requirements
- R1: After reset: busy, complete, error and abort-pending are 0, both chip selects are high, the serial clock is low and no data line is driven.
- R2: Line code 0 skips a phase; codes 1, 2, 3 and 4 select 1, 2, 4 and 8 lines. Values go out most significant bit first. One-line output uses io[0] and one-line input uses io[1]. On a multi-line slot, the highest active line carries the highest of that slot's bits. Phases run in the order instruction, address, dummy, data.
- R3: The address phase sends (size code + 1) bytes of `addr_i`, taking the low-order bytes of the address.
- R4: The dummy phase lasts `dcyc_i` serial clock cycles and drives no line. A count of 0 removes the phase.
- R5: The data phase moves `dlen_i` + 1 bytes. Mode 0 (write) takes them from the transmit FIFO. Mode 1 (read) samples them into the receive FIFO.
- R6: The serial clock idles low. Each high half and each low half lasts `presc_i` + 1 kernel clock cycles.
- R7: `cs_sel_i` picks which of `cs_no[1:0]` goes low; the other stays high. The chip select falls at least one full serial clock period before the first rising serial clock edge. It stays low with the clock low for one serial clock period after the last bit.
- R8: Transfer complete sets when the last bit of the final phase ends, while busy is still 1. Busy drops after the trailing chip-select period. `clr_tc_i` clears the complete flag.
- R9: A launch in mode 2 or 3, with any line code above 4, or while busy sets the error flag and starts nothing. `clr_te_i` clears the error flag.
- R10: An abort request raises `abort_o`. It ends any transaction with the chip selects released, does not set complete, empties both FIFOs, and `abort_o` clears by itself within three cycles.
- R11: In a data phase, an empty transmit FIFO (write) or a full receive FIFO (read) holds the serial clock low with the chip select still active, until the FIFO condition clears.
- R12: `wready_o` is low while the transmit FIFO holds its full depth, and a byte offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmode_i | input | 2 | Function mode: 0 write, 1 read, 2 and 3 rejected |
| cs_sel_i | input | 1 | Chip select choice |
| presc_i | input | 8 | Serial clock prescaler |
| imode_i | input | 3 | Instruction line code |
| admode_i | input | 3 | Address line code |
| adsize_i | input | 2 | Address bytes minus one |
| dcyc_i | input | 5 | Dummy cycle count |
| dmode_i | input | 3 | Data line code |
| dlen_i | input | 16 | Data bytes minus one |
| addr_i | input | 32 | Address value |
| opcode_i | input | 8 | Instruction opcode |
| launch_i | input | 1 | Start strobe (instruction write) |
| abort_i | input | 1 | Abort request strobe |
| clr_tc_i | input | 1 | Clear transfer complete |
| clr_te_i | input | 1 | Clear transfer error |
| wdata_i | input | 8 | Transmit byte |
| wvalid_i | input | 1 | Transmit byte valid |
| wready_o | output | 1 | Transmit FIFO has room |
| rdata_o | output | 8 | Received byte at FIFO head |
| rvalid_o | output | 1 | Receive FIFO not empty |
| rready_i | input | 1 | Pop receive FIFO |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 2 | Chip selects, active low |
| io_o | output | 8 | Data line output values |
| io_oe_o | output | 8 | Data line output enables |
| io_i | input | 8 | Data line input values |
| busy_o | output | 1 | Transaction in progress |
| tc_o | output | 1 | Transfer complete flag |
| te_o | output | 1 | Transfer error flag |
| abort_o | output | 1 | Abort pending, self-clearing |

## Verification
A wrong phase state shows up on the bus as soon as the next serial clock edge: the count of rising edges under chip select changes, or the output enables in a dummy or read slot become nonzero. The bench records every rising edge and compares the slot count and the decoded opcode, address and data against the values it programmed. A stuck or miscounted shift path gives a wrong byte within one phase. A broken stall or abort path shows within a few kernel cycles: the serial clock keeps toggling, the chip select stays low, or the abort bit never clears.

// File: rtl/ospi_pkg.sv
package ospi_pkg;
  localparam int ADDR_W = 32;
  localparam int SH_W   = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_INSTR, ST_ADDR, ST_DUMMY, ST_DWAIT, ST_DATA, ST_TRAIL
  } seq_st_e;

  localparam logic [1:0] FM_WRITE = 2'd0;
  localparam logic [1:0] FM_READ  = 2'd1;

  // last slot index for a phase of nbits on the lines given by code (1..4)
  function automatic logic [5:0] slot_last(input logic [5:0] nbits, input logic [2:0] code);
    logic [1:0] lg;
    lg = 2'(code - 3'd1);
    return (nbits >> lg) - 6'd1;
  endfunction

  function automatic logic [7:0] line_mask(input logic [2:0] code);
    case (code)
      3'd1:    return 8'h01;
      3'd2:    return 8'h03;
      3'd3:    return 8'h0F;
      3'd4:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ospi_clkdiv.sv
module ospi_clkdiv #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_div_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= presc_i);
endmodule

// File: rtl/ospi_fifo.sv
module ospi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_drops_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/ospi_fsm.sv
module ospi_fsm
  import ospi_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          abort_i,
  input  logic          clr_tc_i,
  input  logic          clr_te_i,
  input  logic [1:0]    fmode_i,
  input  logic          cs_sel_i,
  input  logic [7:0]    presc_i,
  input  logic [2:0]    imode_i,
  input  logic [2:0]    admode_i,
  input  logic [1:0]    adsize_i,
  input  logic [4:0]    dcyc_i,
  input  logic [2:0]    dmode_i,
  input  logic [LW-1:0] dlen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]    opcode_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic [7:0]    presc_o,
  input  logic          tx_empty_i,
  input  logic [7:0]    tx_data_i,
  output logic          tx_pop_o,
  input  logic          rx_full_i,
  output logic          rx_push_o,
  output logic [7:0]    rx_data_o,
  output logic          flush_o,
  output logic          sck_o,
  output logic [1:0]    cs_no,
  output logic [7:0]    io_o,
  output logic [7:0]    io_oe_o,
  input  logic [7:0]    io_i,
  output logic          busy_o,
  output logic          tc_o,
  output logic          te_o,
  output logic          abort_o
);
  seq_st_e st_q, nxt;
  logic          half_q, sck_q, cs_act_q, abort_q, tc_q, te_q;
  logic [5:0]    cnt_q;
  logic [LW-1:0] bytes_q;
  logic [SH_W-1:0] sh_q;
  logic [7:0]    rxb_q, samp;
  logic          c_rd, c_sel;
  logic [7:0]    c_presc, c_op;
  logic [2:0]    c_im, c_am, c_dm;
  logic [1:0]    c_as;
  logic [4:0]    c_dc;
  logic [ADDR_W-1:0] c_addr;

  logic       bit_ph, adv, accept, valid, data_go, set_tc, set_te;
  logic [2:0] cur_code;
  logic [3:0] lines;
  logic [5:0] a_bits;
  logic [4:0] a_sh;

  assign bit_ph = (st_q == ST_INSTR) || (st_q == ST_ADDR) ||
                  (st_q == ST_DUMMY) || (st_q == ST_DATA);
  assign valid  = (fmode_i[1] == 1'b0) && (imode_i <= 3'd4) &&
                  (admode_i <= 3'd4) && (dmode_i <= 3'd4);
  assign accept = launch_i && (st_q == ST_IDLE) && !abort_q && valid;
  assign set_te = launch_i && !accept;
  assign adv    = tick_i && half_q && !abort_q &&
                  ((st_q == ST_LEAD) || (bit_ph && cnt_q == '0));
  assign set_tc = adv && (nxt == ST_TRAIL);
  assign data_go = !abort_q && (c_rd ? !rx_full_i : !tx_empty_i);

  assign cur_code = (st_q == ST_INSTR) ? c_im : (st_q == ST_ADDR) ? c_am : c_dm;
  assign lines    = 4'd1 << 2'(cur_code - 3'd1);
  assign a_bits   = (6'(c_as) + 6'd1) << 3;
  assign a_sh     = {2'(2'd3 - c_as), 3'b000};

  // next active phase after the current one
  always_comb begin
    unique case (st_q)
      ST_LEAD:  nxt = (c_im != 0) ? ST_INSTR : (c_am != 0) ? ST_ADDR :
                      (c_dc != 0) ? ST_DUMMY : (c_dm != 0) ? ST_DWAIT : ST_TRAIL;
      ST_INSTR: nxt = (c_am != 0) ? ST_ADDR : (c_dc != 0) ? ST_DUMMY :
                      (c_dm != 0) ? ST_DWAIT : ST_TRAIL;
      ST_ADDR:  nxt = (c_dc != 0) ? ST_DUMMY : (c_dm != 0) ? ST_DWAIT : ST_TRAIL;
      ST_DUMMY: nxt = (c_dm != 0) ? ST_DWAIT : ST_TRAIL;
      ST_DATA:  nxt = (bytes_q != '0) ? ST_DWAIT : ST_TRAIL;
      default:  nxt = ST_TRAIL;
    endcase
  end

  always_comb begin
    case (c_dm)
      3'd1:    samp = {rxb_q[6:0], io_i[1]};
      3'd2:    samp = {rxb_q[5:0], io_i[1:0]};
      3'd3:    samp = {rxb_q[3:0], io_i[3:0]};
      default: samp = io_i;
    endcase
  end

  always_comb begin
    case (cur_code)
      3'd1:    io_o = {7'b0, sh_q[SH_W-1]};
      3'd2:    io_o = {6'b0, sh_q[SH_W-1 -: 2]};
      3'd3:    io_o = {4'b0, sh_q[SH_W-1 -: 4]};
      3'd4:    io_o = sh_q[SH_W-1 -: 8];
      default: io_o = 8'h00;
    endcase
    if ((st_q == ST_INSTR) || (st_q == ST_ADDR) || (st_q == ST_DATA && !c_rd))
      io_oe_o = line_mask(cur_code);
    else
      io_oe_o = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;   half_q <= 1'b0; sck_q <= 1'b0; cs_act_q <= 1'b0;
      abort_q <= 1'b0;   tc_q <= 1'b0;   te_q <= 1'b0;  cnt_q <= '0;
      bytes_q <= '0;     sh_q <= '0;     rxb_q <= '0;
      c_rd <= 1'b0; c_sel <= 1'b0; c_presc <= '0; c_op <= '0;
      c_im <= '0; c_am <= '0; c_dm <= '0; c_as <= '0; c_dc <= '0; c_addr <= '0;
    end else begin
      if (abort_i)                           abort_q <= 1'b1;
      else if (abort_q && st_q == ST_IDLE)   abort_q <= 1'b0;
      if (set_tc)        tc_q <= 1'b1;
      else if (clr_tc_i) tc_q <= 1'b0;
      if (set_te)        te_q <= 1'b1;
      else if (clr_te_i) te_q <= 1'b0;

      if (abort_q && st_q != ST_IDLE) begin
        st_q <= ST_IDLE; cs_act_q <= 1'b0; sck_q <= 1'b0; half_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (accept) begin
            st_q <= ST_LEAD; cs_act_q <= 1'b1; half_q <= 1'b0;
            c_rd <= (fmode_i == FM_READ); c_sel <= cs_sel_i; c_presc <= presc_i;
            c_op <= opcode_i; c_im <= imode_i; c_am <= admode_i; c_dm <= dmode_i;
            c_as <= adsize_i; c_dc <= dcyc_i; c_addr <= addr_i; bytes_q <= dlen_i;
          end
          ST_DWAIT: if (data_go) begin
            st_q <= ST_DATA; half_q <= 1'b0;
            cnt_q <= slot_last(6'd8, c_dm);
            if (!c_rd) sh_q <= {tx_data_i, {(SH_W-8){1'b0}}};
          end
          default: if (tick_i) begin
            if (!half_q) begin
              half_q <= 1'b1;
              if (bit_ph) sck_q <= 1'b1;
              if (st_q == ST_DATA && c_rd) rxb_q <= samp;
            end else begin
              half_q <= 1'b0; sck_q <= 1'b0;
              if (bit_ph && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                sh_q  <= sh_q << lines;
              end else if (st_q == ST_TRAIL) begin
                st_q <= ST_IDLE; cs_act_q <= 1'b0;
              end else begin
                st_q <= nxt;
                if (st_q == ST_DATA && bytes_q != '0) bytes_q <= bytes_q - 1'b1;
                case (nxt)
                  ST_INSTR: begin
                    sh_q  <= {c_op, {(SH_W-8){1'b0}}};
                    cnt_q <= slot_last(6'd8, c_im);
                  end
                  ST_ADDR: begin
                    sh_q  <= c_addr << a_sh;
                    cnt_q <= slot_last(a_bits, c_am);
                  end
                  ST_DUMMY: cnt_q <= 6'(c_dc) - 6'd1;
                  default: ;
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  assign run_o     = (st_q != ST_IDLE) && (st_q != ST_DWAIT);
  assign presc_o   = c_presc;
  assign tx_pop_o  = (st_q == ST_DWAIT) && data_go && !c_rd;
  assign rx_push_o = adv && (st_q == ST_DATA) && c_rd;
  assign rx_data_o = rxb_q;
  assign flush_o   = abort_q && (st_q == ST_IDLE);
  assign sck_o     = sck_q;
  assign cs_no     = !cs_act_q ? 2'b11 : (c_sel ? 2'b01 : 2'b10);
  assign busy_o    = (st_q != ST_IDLE);
  assign tc_o      = tc_q;
  assign te_o      = te_q;
  assign abort_o   = abort_q;

  assert_cs_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no == 2'b11 && !sck_o && io_oe_o == 8'h00));
  assert_sck_in_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> bit_ph);
  assert_abort_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && busy_o) |=> !busy_o);
  assert_abort_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !busy_o && !abort_i) |=> !abort_o);
  assert_tc_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> busy_o);
endmodule

// File: rtl/ospi_seq.sv
module ospi_seq #(
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmode_i,
  input  logic             cs_sel_i,
  input  logic [7:0]       presc_i,
  input  logic [2:0]       imode_i,
  input  logic [2:0]       admode_i,
  input  logic [1:0]       adsize_i,
  input  logic [4:0]       dcyc_i,
  input  logic [2:0]       dmode_i,
  input  logic [LEN_W-1:0] dlen_i,
  input  logic [31:0]      addr_i,
  input  logic [7:0]       opcode_i,
  input  logic             launch_i,
  input  logic             abort_i,
  input  logic             clr_tc_i,
  input  logic             clr_te_i,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic             sck_o,
  output logic [1:0]       cs_no,
  output logic [7:0]       io_o,
  output logic [7:0]       io_oe_o,
  input  logic [7:0]       io_i,
  output logic             busy_o,
  output logic             tc_o,
  output logic             te_o,
  output logic             abort_o
);
  logic       run, tick, flush;
  logic [7:0] presc_l;
  logic       tx_pop, tx_full, tx_empty;
  logic [7:0] tx_data;
  logic       rx_push, rx_full, rx_empty;
  logic [7:0] rx_data;

  ospi_clkdiv #(.PW(8)) u_div (
    .clk_i, .rst_ni, .run_i(run), .presc_i(presc_l), .tick_o(tick)
  );

  ospi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(wvalid_i), .wdata_i(wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_data), .full_o(tx_full), .empty_o(tx_empty)
  );

  ospi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push), .wdata_i(rx_data), .pop_i(rready_i),
    .rdata_o(rdata_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  ospi_fsm #(.LW(LEN_W)) u_fsm (
    .clk_i, .rst_ni,
    .launch_i, .abort_i, .clr_tc_i, .clr_te_i,
    .fmode_i, .cs_sel_i, .presc_i, .imode_i, .admode_i, .adsize_i,
    .dcyc_i, .dmode_i, .dlen_i, .addr_i, .opcode_i,
    .tick_i(tick), .run_o(run), .presc_o(presc_l),
    .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data),
    .flush_o(flush),
    .sck_o, .cs_no, .io_o, .io_oe_o, .io_i,
    .busy_o, .tc_o, .te_o, .abort_o
  );

  assign wready_o = !tx_full;
  assign rvalid_o = !rx_empty;
endmodule

// File: tb/tb_ospi_seq.sv
module tb_ospi_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmode = '0; logic cs_sel = 1'b0; logic [7:0] presc = '0;
  logic [2:0] imode = '0, admode = '0, dmode = '0; logic [1:0] adsize = '0;
  logic [4:0] dcyc = '0; logic [15:0] dlen = '0; logic [31:0] addr = '0;
  logic [7:0] opcode = '0;
  logic launch = 0, abort_r = 0, clr_tc = 0, clr_te = 0;
  logic [7:0] wdata = '0; logic wvalid = 0, rready = 0;
  logic wready, rvalid, sck, busy, tc, te, abt;
  logic [7:0] rdata, io_out, io_oe, io_in = '0;
  logic [1:0] cs_n;

  int checks = 0, fails = 0, cyc = 0, n = 0;
  logic [7:0] cap_o [CAP]; logic [7:0] cap_oe [CAP]; logic [1:0] cap_cs [CAP];
  int cap_t [CAP]; logic [7:0] rd_slots [CAP];

  ospi_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .fmode_i(fmode), .cs_sel_i(cs_sel), .presc_i(presc),
    .imode_i(imode), .admode_i(admode), .adsize_i(adsize), .dcyc_i(dcyc),
    .dmode_i(dmode), .dlen_i(dlen), .addr_i(addr), .opcode_i(opcode),
    .launch_i(launch), .abort_i(abort_r), .clr_tc_i(clr_tc), .clr_te_i(clr_te),
    .wdata_i(wdata), .wvalid_i(wvalid), .wready_o(wready), .rdata_o(rdata),
    .rvalid_o(rvalid), .rready_i(rready), .sck_o(sck), .cs_no(cs_n),
    .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in), .busy_o(busy), .tc_o(tc),
    .te_o(te), .abort_o(abt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge sck) begin
    if (n < CAP) begin
      cap_o[n] = io_out; cap_oe[n] = io_oe; cap_cs[n] = cs_n; cap_t[n] = cyc;
    end
    n++;
  end
  always @(negedge sck) if (n < CAP) io_in = rd_slots[n];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] get_bits(input int start, input int cnt, input int code);
    logic [31:0] v = '0;
    for (int k = 0; k < cnt; k++) begin
      case (code)
        1: v = {v[30:0], cap_o[start+k][0]};
        2: v = {v[29:0], cap_o[start+k][1:0]};
        3: v = {v[27:0], cap_o[start+k][3:0]};
        default: v = {v[23:0], cap_o[start+k]};
      endcase
    end
    return v;
  endfunction

  task automatic setcfg(input logic [1:0] fm, input logic sel, input logic [7:0] p,
                        input logic [2:0] im, input logic [2:0] am, input logic [1:0] as,
                        input logic [4:0] dc, input logic [2:0] dm, input logic [15:0] len,
                        input logic [7:0] op, input logic [31:0] ad);
    @(negedge clk);
    fmode = fm; cs_sel = sel; presc = p; imode = im; admode = am; adsize = as;
    dcyc = dc; dmode = dm; dlen = len; opcode = op; addr = ad;
  endtask

  task automatic clear_cap;
    for (int k = 0; k < CAP; k++) rd_slots[k] = 8'h00;
    n = 0; io_in = 8'h00;
  endtask

  task automatic pulse_launch;
    @(negedge clk); launch = 1; @(negedge clk); launch = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); wdata = b; wvalid = 1; @(negedge clk); wvalid = 0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk); b = rdata; rready = 1; @(negedge clk); rready = 0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic wait_tc_check_trail(input string tag);
    for (int k = 0; k < 20000 && !tc; k++) @(negedge clk);
    chk({tag, " R8 tc set"}, tc, 1);
    chk({tag, " R8 busy at tc"}, busy, 1);
    chk({tag, " R7 trail cs low"}, (cs_n != 2'b11), 1);
    chk({tag, " R7 trail sck low"}, sck, 0);
  endtask

  task automatic clr_flags;
    @(negedge clk); clr_tc = 1; clr_te = 1; @(negedge clk); clr_tc = 0; clr_te = 0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 tc", tc, 0); chk("R1 te", te, 0);
    chk("R1 abort", abt, 0); chk("R1 cs", cs_n, 2'b11); chk("R1 sck", sck, 0);
    chk("R1 oe", io_oe, 0); chk("R1 rvalid", rvalid, 0); chk("R12 wready", wready, 1);
  endtask

  task automatic t_single_write;
    clear_cap();
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    setcfg(2'd0, 1'b0, 8'd1, 3'd1, 3'd1, 2'd2, 5'd0, 3'd1, 16'd2, 8'h9E, 32'h00123456);
    pulse_launch();
    chk("R7 lead cs0 low", cs_n, 2'b10); chk("R7 lead sck low", sck, 0);
    wait_tc_check_trail("sw");
    wait_idle();
    chk("R4 R2 sw slot count", n, 56);
    chk("R2 sw opcode", get_bits(0, 8, 1), 32'h9E);
    chk("R2 sw oe single", cap_oe[0], 8'h01);
    chk("R3 sw addr 24b", get_bits(8, 24, 1), 32'h123456);
    chk("R5 sw data", get_bits(32, 24, 1), 32'h112233);
    chk("R6 sw period", cap_t[1] - cap_t[0], 4);
    chk("R7 sw cs sel", cap_cs[10], 2'b10);
    chk("R8 sw busy low", busy, 0); chk("R7 sw cs release", cs_n, 2'b11);
    clr_flags(); chk("R8 tc cleared", tc, 0);
  endtask

  task automatic t_quad_read;
    logic [7:0] exp [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F};
    logic [7:0] b;
    logic ok_oe;
    clear_cap();
    for (int i = 0; i < 4; i++) begin
      rd_slots[22 + 2*i] = {4'h0, exp[i][7:4]};
      rd_slots[23 + 2*i] = {4'h0, exp[i][3:0]};
    end
    setcfg(2'd1, 1'b1, 8'd0, 3'd1, 3'd3, 2'd3, 5'd6, 3'd3, 16'd3, 8'hEB, 32'hDEADBEEF);
    pulse_launch();
    wait_tc_check_trail("qr");
    wait_idle();
    chk("R2 qr slot count", n, 30);
    chk("R3 qr addr 32b quad", get_bits(8, 8, 3), 32'hDEADBEEF);
    chk("R2 qr oe quad", cap_oe[8], 8'h0F);
    ok_oe = 1;
    for (int k = 16; k < 30; k++) if (cap_oe[k] != 8'h00) ok_oe = 0;
    chk("R4 qr dummy and read undriven", ok_oe, 1);
    chk("R6 qr period presc0", cap_t[1] - cap_t[0], 2);
    chk("R7 qr cs1", cap_cs[5], 2'b01);
    for (int i = 0; i < 4; i++) begin
      pop_byte(b);
      chk("R5 qr rx byte", b, exp[i]);
    end
    chk("R5 qr rx drained", rvalid, 0);
    clr_flags();
  endtask

  task automatic t_octal_instr;
    clear_cap();
    setcfg(2'd0, 1'b0, 8'd2, 3'd4, 3'd0, 2'd0, 5'd0, 3'd0, 16'd0, 8'hC3, 32'h0);
    pulse_launch();
    wait_tc_check_trail("oi");
    wait_idle();
    chk("R2 oi slot count", n, 1);
    chk("R2 oi opcode", cap_o[0], 8'hC3);
    chk("R2 oi oe", cap_oe[0], 8'hFF);
    clr_flags();
  endtask

  task automatic t_dual_write;
    clear_cap();
    push_byte(8'hA1); push_byte(8'h5E);
    setcfg(2'd0, 1'b0, 8'd0, 3'd2, 3'd2, 2'd0, 5'd0, 3'd2, 16'd1, 8'h3B, 32'h0000007C);
    pulse_launch();
    wait_idle();
    chk("R2 dw slot count", n, 16);
    chk("R2 dw opcode", get_bits(0, 4, 2), 32'h3B);
    chk("R3 dw addr 8b", get_bits(4, 4, 2), 32'h7C);
    chk("R5 dw data", get_bits(8, 8, 2), 32'hA15E);
    chk("R2 dw oe", cap_oe[0], 8'h03);
    clr_flags();
  endtask

  task automatic t_errors;
    clear_cap();
    setcfg(2'd2, 1'b0, 8'd0, 3'd1, 3'd0, 2'd0, 5'd0, 3'd0, 16'd0, 8'h05, 32'h0);
    pulse_launch();
    repeat (4) @(negedge clk);
    chk("R9 mode2 te", te, 1); chk("R9 mode2 no busy", busy, 0);
    chk("R9 mode2 cs idle", cs_n, 2'b11);
    clr_flags(); chk("R9 te cleared", te, 0);
    setcfg(2'd0, 1'b0, 8'd0, 3'd1, 3'd5, 2'd0, 5'd0, 3'd0, 16'd0, 8'h05, 32'h0);
    pulse_launch();
    repeat (4) @(negedge clk);
    chk("R9 bad code te", te, 1); chk("R9 bad code no busy", busy, 0);
    clr_flags();
    clear_cap();
    setcfg(2'd0, 1'b0, 8'd5, 3'd4, 3'd0, 2'd0, 5'd0, 3'd0, 16'd0, 8'h66, 32'h0);
    pulse_launch();
    repeat (2) @(negedge clk);
    pulse_launch();
    chk("R9 busy launch te", te, 1); chk("R9 busy still", busy, 1);
    wait_idle();
    chk("R9 busy launch one txn", n, 1);
    chk("R9 busy launch opcode", cap_o[0], 8'h66);
    clr_flags();
  endtask

  task automatic t_abort;
    int k;
    clear_cap();
    setcfg(2'd1, 1'b0, 8'd3, 3'd1, 3'd0, 2'd0, 5'd0, 3'd1, 16'd15, 8'h03, 32'h0);
    pulse_launch();
    for (k = 0; k < 20000 && n < 20; k++) @(negedge clk);
    chk("R10 abort pre rx byte", rvalid, 1);
    @(negedge clk); abort_r = 1; @(negedge clk); abort_r = 0;
    chk("R10 abort pending", abt, 1);
    for (k = 0; k < 3 && abt; k++) @(negedge clk);
    chk("R10 abort self clear", abt, 0);
    chk("R10 busy low", busy, 0); chk("R10 cs released", cs_n, 2'b11);
    chk("R10 no tc", tc, 0); chk("R10 rx flushed", rvalid, 0);
    clr_flags();
  endtask

  task automatic t_stall;
    int n0;
    clear_cap();
    push_byte(8'h5A);
    setcfg(2'd0, 1'b1, 8'd0, 3'd0, 3'd0, 2'd0, 5'd0, 3'd1, 16'd1, 8'h00, 32'h0);
    pulse_launch();
    repeat (200) @(negedge clk);
    n0 = n;
    chk("R11 stall slots", n0, 8);
    chk("R11 stall busy", busy, 1); chk("R11 stall sck low", sck, 0);
    chk("R11 stall cs low", cs_n, 2'b01);
    repeat (50) @(negedge clk);
    chk("R11 stall held", n, n0);
    push_byte(8'h96);
    wait_idle();
    chk("R11 resumed slots", n, 16);
    chk("R11 stall data", get_bits(0, 16, 1), 32'h5A96);
    clr_flags();
  endtask

  task automatic t_fifo_full;
    clear_cap();
    for (int i = 1; i <= 4; i++) push_byte(8'(i));
    chk("R12 wready low full", wready, 0);
    push_byte(8'hEE);
    setcfg(2'd0, 1'b0, 8'd0, 3'd0, 3'd0, 2'd0, 5'd0, 3'd4, 16'd3, 8'h00, 32'h0);
    pulse_launch();
    wait_idle();
    chk("R12 octal slots", n, 4);
    chk("R12 dropped byte absent", get_bits(0, 4, 4), 32'h01020304);
    chk("R12 wready back", wready, 1);
    clr_flags();
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_cap();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_quad_read();
    t_octal_instr();
    t_dual_write();
    t_errors();
    t_abort();
    t_stall();
    t_fifo_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule